// File: doc/BRIEF.md
# Two-Pixel Demultiplexed Video Output Stage

This block sits at the end of an on-screen display pipeline. It receives one colour code and one display-period flag per dot clock, and drives two output ports. Each port has a colour bus and a period strobe. In straight mode the whole dot stream leaves on port A. In demultiplexed mode the stream is split into pairs: the even dot of each pair leaves on port A and the odd dot on port B. Each port then updates once every two dots, which halves the rate a downstream panel interface has to accept.

Dot pairing is anchored to an event the integrator selects. The event is either the rising edge of the internal line sync or the assertion of the display-enable input, and it can be taken as is or one dot clock late. The two ports can change on the same edge, or they can be staggered so that port B trails port A by one dot clock.

The display-enable input has a programmable active level. While it is inactive, the dots being presented are blanked. The colour outputs and the strobe outputs each have their own polarity control. All configuration inputs are expected to stay stable during a line. The reset input is asynchronous and active low, and it is expected to be released in step with the clock.

Top module: `pix_pair_demux`

## Requirements
- R1: With `demux_en`=0, the dot presented in clock cycle i appears on port A after clock edge i. Port B colour and strobe stay at their inactive level.
- R2: With `demux_en`=1, the dots are grouped into consecutive pairs. The first dot of a pair (even) goes to port A and the second (odd) to port B.
- R3: With `two_phase`=0 in demultiplexed mode, both ports load a pair on the clock edge of its odd dot. Both ports then hold that pair for two dot clocks.
- R4: With `two_phase`=1 in demultiplexed mode, port A loads on the edge of the odd dot, and port B loads the odd dot one clock edge later.
- R5: With `anchor_src`=0, a dot presented in a cycle where `line_sync` has risen (high now, low the cycle before) is an even dot. Later dots alternate between odd and even. This applies even when the new anchor lands in the middle of a pair.
- R6: With `anchor_src`=1, the first dot presented while display-enable is active after a cycle in which it was inactive is an even dot.
- R7: With `anchor_lag`=1, the anchor moves one dot clock later than the selected event, so the dot that follows the event is the even dot.
- R8: Display-enable is active when `disp_en` differs from `en_pol`. A dot presented while display-enable is inactive is carried as colour 0 with its strobe low.
- R9: `col_inv`=1 inverts every bit of both colour outputs. The inactive colour level is then all ones.
- R10: `str_inv`=1 inverts both strobe outputs. The inactive strobe level is then 1.
- R11: During and after reset, all outputs sit at their inactive level, and the first dot after reset is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dot_col | input | CW | Colour code of the current dot |
| dot_val | input | 1 | Display-period flag of the current dot |
| line_sync | input | 1 | Internal horizontal sync, active high |
| disp_en | input | 1 | Display-enable input, active level set by en_pol |
| demux_en | input | 1 | 0 straight output, 1 two-pixel output |
| two_phase | input | 1 | 0 ports change together, 1 port B one clock later |
| anchor_src | input | 1 | Pairing anchor: 0 line sync rise, 1 enable assertion |
| anchor_lag | input | 1 | Delay the pairing anchor by one clock |
| en_pol | input | 1 | 1 makes disp_en active low |
| col_inv | input | 1 | Invert colour outputs |
| str_inv | input | 1 | Invert strobe outputs |
| a_col | output | CW | Port A colour |
| a_str | output | 1 | Port A period strobe |
| b_col | output | CW | Port B colour |
| b_str | output | 1 | Port B period strobe |

## Verification
The bench builds the block with the default colour width of 4. At that width every colour code can be checked against its bitwise inverse, and the all-ones inactive level under inversion is easy to tell apart from a passing dot. The stimulus uses distinct colour codes and occasional low strobes. These make a swapped even/odd pair, a one-cycle slip of the stagger, or a misplaced anchor show up as a mismatch at a known cycle. One line re-anchors on an odd position, and one line toggles display-enable in the middle of the stream.

// File: rtl/pxd_pkg.sv
package pxd_pkg;

  // Event used to restart even/odd dot pairing.
  typedef enum logic {
    ANC_LINE = 1'b0,
    ANC_EN   = 1'b1
  } anc_src_e;

endpackage

// File: rtl/pxd_anchor.sv
module pxd_anchor
  import pxd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     line_sync,
  input  logic     en_act,
  input  anc_src_e src,
  input  logic     lag,
  output logic     anchor,
  output logic     is_even
);

  logic sync_q, sync_d;
  logic en_q, en_d;
  logic raw_q, raw_d;
  logic odd_next_q, odd_next_d;
  logic raw_evt;

  // Event detection and optional one-clock lag.
  always_comb begin
    if (src == ANC_EN) raw_evt = en_act & ~en_q;
    else               raw_evt = line_sync & ~sync_q;
    anchor     = lag ? raw_q : raw_evt;
    is_even    = anchor | ~odd_next_q;
    sync_d     = line_sync;
    en_d       = en_act;
    raw_d      = raw_evt;
    odd_next_d = is_even;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= 1'b0;
      en_q       <= 1'b0;
      raw_q      <= 1'b0;
      odd_next_q <= 1'b0;
    end else begin
      sync_q     <= sync_d;
      en_q       <= en_d;
      raw_q      <= raw_d;
      odd_next_q <= odd_next_d;
    end
  end

  // Two odd dots never follow each other.
  AST_NO_DOUBLE_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    !is_even |=> is_even); // R2

endmodule

// File: rtl/pxd_lane.sv
module pxd_lane #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          clr,
  input  logic [CW-1:0] din_col,
  input  logic          din_str,
  input  logic          col_inv,
  input  logic          str_inv,
  output logic [CW-1:0] out_col,
  output logic          out_str
);

  logic [CW-1:0] col_q, col_d;
  logic          str_q, str_d;

  always_comb begin
    col_d = col_q;
    str_d = str_q;
    if (clr) begin
      col_d = '0;
      str_d = 1'b0;
    end else if (load) begin
      col_d = din_col;
      str_d = din_str;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      str_q <= 1'b0;
    end else begin
      col_q <= col_d;
      str_q <= str_d;
    end
  end

  // Polarity is applied after the register so reset always gives the inactive level.
  assign out_col = col_q ^ {CW{col_inv}};
  assign out_str = str_q ^ str_inv;

  AST_CLR_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (out_col == {CW{col_inv}}) && (out_str == str_inv)); // R1

endmodule

// File: rtl/pix_pair_demux.sv
module pix_pair_demux
  import pxd_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] dot_col,
  input  logic          dot_val,
  input  logic          line_sync,
  input  logic          disp_en,
  input  logic          demux_en,
  input  logic          two_phase,
  input  logic          anchor_src,
  input  logic          anchor_lag,
  input  logic          en_pol,
  input  logic          col_inv,
  input  logic          str_inv,
  output logic [CW-1:0] a_col,
  output logic          a_str,
  output logic [CW-1:0] b_col,
  output logic          b_str
);

  localparam int NLANE = 2;

  logic          en_act;
  logic [CW-1:0] g_col;
  logic          g_str;
  logic          anchor, is_even;

  logic [CW-1:0] ehold_col_q, ehold_col_d;
  logic          ehold_str_q, ehold_str_d;
  logic [CW-1:0] ohold_col_q, ohold_col_d;
  logic          ohold_str_q, ohold_str_d;
  logic          pend_q, pend_d;

  logic [NLANE-1:0]         ln_load, ln_clr, ln_str, ln_ostr;
  logic [NLANE-1:0][CW-1:0] ln_col, ln_ocol;

  // Display-enable gating of the incoming dot (R8).
  assign en_act = disp_en ^ en_pol;
  assign g_col  = en_act ? dot_col : '0;
  assign g_str  = en_act & dot_val;

  pxd_anchor u_anchor (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_sync (line_sync),
    .en_act    (en_act),
    .src       (anc_src_e'(anchor_src)),
    .lag       (anchor_lag),
    .anchor    (anchor),
    .is_even   (is_even)
  );

  // Steering: even dot waits in ehold, odd dot optionally waits in ohold.
  always_comb begin
    ehold_col_d = ehold_col_q;
    ehold_str_d = ehold_str_q;
    ohold_col_d = ohold_col_q;
    ohold_str_d = ohold_str_q;
    if (is_even) begin
      ehold_col_d = g_col;
      ehold_str_d = g_str;
    end else begin
      ohold_col_d = g_col;
      ohold_str_d = g_str;
    end
    pend_d = demux_en & two_phase & ~is_even;

    ln_clr[0]  = 1'b0;
    ln_load[0] = demux_en ? ~is_even : 1'b1;
    ln_col[0]  = demux_en ? ehold_col_q : g_col;
    ln_str[0]  = demux_en ? ehold_str_q : g_str;

    ln_clr[1]  = ~demux_en;
    ln_load[1] = two_phase ? pend_q : ~is_even;
    ln_col[1]  = two_phase ? ohold_col_q : g_col;
    ln_str[1]  = two_phase ? ohold_str_q : g_str;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ehold_col_q <= '0;
      ehold_str_q <= 1'b0;
      ohold_col_q <= '0;
      ohold_str_q <= 1'b0;
      pend_q      <= 1'b0;
    end else begin
      ehold_col_q <= ehold_col_d;
      ehold_str_q <= ehold_str_d;
      ohold_col_q <= ohold_col_d;
      ohold_str_q <= ohold_str_d;
      pend_q      <= pend_d;
    end
  end

  for (genvar gi = 0; gi < NLANE; gi++) begin : g_lane
    pxd_lane #(.CW(CW)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ln_load[gi]),
      .clr     (ln_clr[gi]),
      .din_col (ln_col[gi]),
      .din_str (ln_str[gi]),
      .col_inv (col_inv),
      .str_inv (str_inv),
      .out_col (ln_ocol[gi]),
      .out_str (ln_ostr[gi])
    );
  end

  assign a_col = ln_ocol[0];
  assign a_str = ln_ostr[0];
  assign b_col = ln_ocol[1];
  assign b_str = ln_ostr[1];

  AST_B_IDLE_STRAIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !demux_en |=> (b_col == {CW{col_inv}}) && (b_str == str_inv)); // R1
  AST_SYNC_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (demux_en && !two_phase) |-> (ln_load[0] == ln_load[1])); // R3
  AST_STAGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (demux_en && two_phase && ln_load[0]) |=> (ln_load[1] && !ln_load[0])); // R4
  AST_ANCHOR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (demux_en && anchor) |-> !ln_load[0]); // R5
  AST_GATE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (!demux_en && !en_act) |=> (a_str == str_inv) && (a_col == {CW{col_inv}})); // R8

endmodule

// File: tb/pix_pair_demux_bench.sv
module pix_pair_demux_bench;

  localparam int CW   = 4;
  localparam int NMAX = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] dot_col;
  logic          dot_val, line_sync, disp_en;
  logic          demux_en, two_phase, anchor_src, anchor_lag, en_pol, col_inv, str_inv;
  logic [CW-1:0] a_col, b_col;
  logic          a_str, b_str;

  int n_checks = 0;
  int n_errors = 0;

  logic [CW-1:0] s_col  [NMAX];
  logic          s_val  [NMAX];
  logic          s_sync [NMAX];
  logic          s_en   [NMAX];

  always #2 clk = ~clk;

  pix_pair_demux #(.CW(CW)) u_pix_pair_demux (
    .clk, .rst_n, .dot_col, .dot_val, .line_sync, .disp_en,
    .demux_en, .two_phase, .anchor_src, .anchor_lag, .en_pol,
    .col_inv, .str_inv, .a_col, .a_str, .b_col, .b_str
  );

  initial begin
    #(200000 * 4);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) begin
      s_col[i]  = CW'((i * 5 + 3) % 16);
      s_val[i]  = (i % 7) != 6;
      s_sync[i] = (i == 0);
      s_en[i]   = 1'b1;
    end
  endtask

  task automatic do_reset(input logic dm, tp, src, lag, ep, ci, si);
    @(negedge clk);
    rst_n = 1'b0;
    demux_en = dm; two_phase = tp; anchor_src = src; anchor_lag = lag;
    en_pol = ep; col_inv = ci; str_inv = si;
    dot_col = '0; dot_val = 1'b0; line_sync = 1'b0; disp_en = ep;
    @(negedge clk);
    @(negedge clk);
  endtask

  // Runs n dots from the stimulus arrays and compares every output each cycle.
  task automatic run_case(input string req, input logic dm, tp, src, lag, ep, ci, si, input int n);
    logic [CW-1:0] ea_c, eb_c, eh_c, oh_c, gc;
    logic ea_s, eb_s, eh_s, oh_s, gs;
    logic p_sync, p_en, raw, raw_p, anc, even, odd_next, pend;
    do_reset(dm, tp, src, lag, ep, ci, si);
    ea_c = '0; eb_c = '0; eh_c = '0; oh_c = '0;
    ea_s = 0; eb_s = 0; eh_s = 0; oh_s = 0;
    p_sync = 0; p_en = 0; raw_p = 0; odd_next = 0; pend = 0;
    rst_n = 1'b1;
    for (int i = 0; i < n; i++) begin
      dot_col = s_col[i]; dot_val = s_val[i];
      line_sync = s_sync[i]; disp_en = s_en[i] ^ ep;
      // pairing rule from R5/R6/R7/R11
      raw = src ? (s_en[i] & ~p_en) : (s_sync[i] & ~p_sync);
      anc = lag ? raw_p : raw;
      even = anc | ~odd_next;
      odd_next = even;
      raw_p = raw; p_en = s_en[i]; p_sync = s_sync[i];
      gc = s_en[i] ? s_col[i] : '0;
      gs = s_en[i] & s_val[i];
      if (!dm) begin
        ea_c = gc; ea_s = gs; eb_c = '0; eb_s = 0;
      end else begin
        if (tp && pend) begin eb_c = oh_c; eb_s = oh_s; end
        if (even) begin
          eh_c = gc; eh_s = gs;
        end else begin
          ea_c = eh_c; ea_s = eh_s;
          if (!tp) begin eb_c = gc; eb_s = gs; end
          oh_c = gc; oh_s = gs;
        end
        pend = tp & ~even;
      end
      @(negedge clk);
      chk(req, $sformatf("a_col dot %0d", i), int'(a_col), int'(ea_c ^ {CW{ci}}));
      chk(req, $sformatf("a_str dot %0d", i), int'(a_str), int'(ea_s ^ si));
      chk(req, $sformatf("b_col dot %0d", i), int'(b_col), int'(eb_c ^ {CW{ci}}));
      chk(req, $sformatf("b_str dot %0d", i), int'(b_str), int'(eb_s ^ si));
    end
  endtask

  task automatic t_reset;
    do_reset(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R11 R9", "a_col in reset", int'(a_col), 15);
    chk("R11 R10", "a_str in reset", int'(a_str), 1);
    chk("R11", "b_col in reset", int'(b_col), 15);
    chk("R11", "b_str in reset", int'(b_str), 1);
    rst_n = 1'b1;
  endtask

  task automatic t_straight;
    fill(20);
    run_case("R1", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 20);
  endtask

  task automatic t_demux_sync;
    fill(24);
    s_sync[11] = 1'b1; // re-anchor in mid-pair
    run_case("R2 R3 R5", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 24);
  endtask

  task automatic t_demux_lag;
    fill(24);
    s_sync[9] = 1'b1;
    run_case("R7", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 24);
  endtask

  task automatic t_two_phase;
    fill(24);
    s_sync[14] = 1'b1;
    run_case("R4", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 24);
  endtask

  task automatic t_enable_anchor;
    fill(28);
    for (int i = 0; i < 28; i++) s_en[i] = !((i < 3) || (i >= 16 && i < 19));
    run_case("R6 R8", 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 28);
  endtask

  task automatic t_gating;
    fill(20);
    for (int i = 0; i < 20; i++) s_en[i] = !(i == 5 || i == 6 || i == 12);
    run_case("R8", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 20);
  endtask

  task automatic t_polarity;
    fill(22);
    s_en[8] = 1'b0;
    run_case("R9 R10", 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 22);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_straight();
    t_demux_sync();
    t_demux_lag();
    t_two_phase();
    t_enable_anchor();
    t_gating();
    t_polarity();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule